// File: doc/BRIEF.md
# Queued-Duty Pulse Width Modulator

This block generates one pulse-width-modulated output. Its time base has two stages. A prescaler divides the system clock by a programmable ratio. A 16-bit period counter then runs off the prescaled ticks. The output is active at the start of each period and goes inactive once the counter reaches the current duty value.

Software does not write the duty value straight into the comparator. Duty words go into a four-entry queue. At each period boundary one entry is moved into the active duty register, so every update takes effect on a whole period and never mid-pulse. Software can read back how many entries are waiting.

A control register holds the enable, the prescale ratio, an output inversion bit, and some stored-only fields. It also holds a self-clearing software reset that clears the queue, the counter and the registers.

Top module: `pwm_fifo_ctrl`

## Requirements
- R1: Registers are at byte offsets 0x00 (control), 0x04 (queue status), 0x0C (duty queue; a read returns the active duty), 0x10 (period, 16 bits). The control register stores bit 0 (enable), bits 15:4 (prescale), bits 17:16 (clock select), bit 18 (invert) and bits 25:22 (mode flags). All other control bits read 0, and any other offset reads 0.
- R2: After reset every register reads 0, the queue is empty and the output is low.
- R3: A write to offset 0x0C appends the low 16 bits to a queue of 4 entries. Status bits 2:0 give the number of queued entries.
- R4: A write to offset 0x0C while 4 entries are queued is dropped, and the queue is left unchanged.
- R5: With prescale field P, the period counter advances once every P+1 clocks.
- R6: One period lasts the period register value plus 2 counter steps.
- R7: In each period the output is active (high before inversion) while the counter is below the active duty, and inactive afterwards. A duty of 0 keeps the output inactive all period. A duty above the period length keeps it active.
- R8: A new period starts one clock after the enable is set, and again at each rollover. At that start the oldest queued entry becomes the active duty. If the queue is empty, the previous duty is kept.
- R9: Control bit 18 inverts the output in every state, including while disabled.
- R10: While enable is 0, the prescaler and counter stay at zero and the output sits at its inactive level. Writing 0 to the control register stops the waveform.
- R11: Writing control with bit 3 set starts a software reset. Bit 3 reads 1 for RST_LEN clocks and then clears. The queue, counter, control, period and active duty are cleared, and register writes are ignored while bit 3 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset (combinational read) |
| rd_data | output | 32 | Read data for rd_addr |
| pwm_out | output | 1 | Modulated output |

## Verification
If the queue level or ordering goes wrong, the status word shows it on its next read. The duty readback and the pulse width show it at the next period start. A counter or prescaler fault moves the falling edge of the pulse, or the start of the next period, within the period being run. A stuck software-reset state shows up in the control readback and in the writes that are dropped. The bench compares the output and a rotating register read against its model on every clock, so each of these faults appears within one period or five clocks of the cause.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;
   // byte offsets of the register window
   localparam int OFF_CTRL = 'h00;
   localparam int OFF_STAT = 'h04;
   localparam int OFF_DUTY = 'h0C;
   localparam int OFF_PER  = 'h10;

   // control field positions
   localparam int BIT_EN   = 0;
   localparam int BIT_SWR  = 3;
   localparam int PS_LSB   = 4;
   localparam int PS_MAXW  = 12;
   localparam int SRC_LSB  = 16;
   localparam int SRC_W    = 2;
   localparam int BIT_POL  = 18;
   localparam int MODE_LSB = 22;
   localparam int MODE_W   = 4;

   function automatic logic [31:0] field_mask(input int lsb, input int w);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] level
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("pwm_sample_fifo: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem     [DEPTH];
   logic [W-1:0]  shifted [DEPTH];
   logic [CW-1:0] level_q;
   logic          full, empty, do_pop, do_push;
   logic [AW-1:0] wr_idx;

   assign full    = (level_q == CW'(DEPTH));
   assign empty   = (level_q == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && !full;
   assign wr_idx  = AW'(level_q - CW'(do_pop));

   // value each slot takes when the head leaves
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_shift
      if (gi < DEPTH - 1) begin : g_mid
         assign shifted[gi] = mem[gi+1];
      end else begin : g_tail
         assign shifted[gi] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (flush) begin
         level_q <= '0;
      end else begin
         if (do_pop) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= shifted[i];
         end
         if (do_push) mem[wr_idx] <= din;
         level_q <= level_q + CW'(do_push) - CW'(do_pop);
      end
   end

   assign dout  = mem[0];
   assign level = level_q;

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= CW'(DEPTH)); // R3
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (level_q == CW'(DEPTH)) && $stable(mem[DEPTH-1])); // R4
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level_q == '0)); // R11
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W = 16,
   parameter int PS_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [PS_W-1:0]  prescale,
   input  logic [CNT_W-1:0] period,
   input  logic             fifo_empty,
   input  logic [CNT_W-1:0] fifo_head,
   output logic             pop,
   output logic             running,
   output logic [CNT_W:0]   count,
   output logic [CNT_W-1:0] duty
);
   logic [PS_W-1:0]  pcnt_q;
   logic [CNT_W:0]   cnt_q;
   logic [CNT_W-1:0] duty_q;
   logic             run_q;
   logic [CNT_W:0]   last;
   logic             tick, wrap, start;

   assign last  = {1'b0, period} + 1'b1;
   assign tick  = (pcnt_q >= prescale);
   assign wrap  = (cnt_q >= last);
   assign start = en && !clr && (!run_q || (tick && wrap));
   assign pop   = start && !fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         duty_q <= '0;
      end else if (clr) begin
         pcnt_q <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         duty_q <= '0;
      end else begin
         if (!en) begin
            pcnt_q <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
         end else if (!run_q) begin
            run_q <= 1'b1;
         end else if (tick) begin
            pcnt_q <= '0;
            cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
         end else begin
            pcnt_q <= pcnt_q + 1'b1;
         end
         if (pop) duty_q <= fifo_head;
      end
   end

   assign running = run_q;
   assign count   = cnt_q;
   assign duty    = duty_q;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0) && (pcnt_q == '0)); // R10
   AST_CNT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && en && !clr && !tick) |=> $stable(cnt_q)); // R5
   AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop && !clr) |=> $stable(duty_q)); // R8
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
   parameter int CNT_W = 16
) (
   input  logic             en,
   input  logic             running,
   input  logic [CNT_W:0]   count,
   input  logic [CNT_W-1:0] duty,
   input  logic             invert,
   output logic             pwm_o
);
   logic active;
   assign active = en && running && (count < {1'b0, duty});
   assign pwm_o  = active ^ invert;
endmodule

// File: rtl/pwm_fifo_ctrl.sv
module pwm_fifo_ctrl
   import pwm_fifo_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int CNT_W      = 16,
   parameter int PS_W       = 12,
   parameter int FIFO_DEPTH = 4,
   parameter int RST_LEN    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              pwm_out
);
   localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
   localparam int RC_W  = $clog2(RST_LEN + 1);
   localparam logic [31:0] CTRL_MASK = field_mask(BIT_EN, 1) | field_mask(PS_LSB, PS_W) |
                                       field_mask(SRC_LSB, SRC_W) | field_mask(BIT_POL, 1) |
                                       field_mask(MODE_LSB, MODE_W);

   generate
      if (CNT_W > 16 || CNT_W < 2) begin : g_bad_cnt
         $error("pwm_fifo_ctrl: CNT_W must be 2..16");
      end
      if (PS_W > PS_MAXW || PS_W < 1) begin : g_bad_ps
         $error("pwm_fifo_ctrl: PS_W must be 1..12");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("pwm_fifo_ctrl: ADDR_W must reach offset 0x10");
      end
      if (FIFO_DEPTH < 1 || FIFO_DEPTH > 7) begin : g_bad_depth
         $error("pwm_fifo_ctrl: FIFO_DEPTH must fit the 3-bit level");
      end
      if (RST_LEN < 1) begin : g_bad_rst
         $error("pwm_fifo_ctrl: RST_LEN must be at least 1");
      end
   endgenerate

   logic [31:0]       ctrl_q;
   logic [CNT_W-1:0]  per_q;
   logic [RC_W-1:0]   rst_cnt_q;
   logic              busy, wr_ok, sel_ctrl, sel_per, sel_duty, swr_req, clr;
   logic              pop, fifo_empty, running;
   logic [CNT_W-1:0]  fifo_head, duty;
   logic [CNT_W:0]    count;
   logic [LVL_W-1:0]  level;

   assign busy     = (rst_cnt_q != '0);
   assign wr_ok    = wr_en && !busy;
   assign sel_ctrl = wr_ok && (wr_addr == ADDR_W'(OFF_CTRL));
   assign sel_per  = wr_ok && (wr_addr == ADDR_W'(OFF_PER));
   assign sel_duty = wr_ok && (wr_addr == ADDR_W'(OFF_DUTY));
   assign swr_req  = sel_ctrl && wr_data[BIT_SWR];
   assign clr      = swr_req || busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         per_q     <= '0;
         rst_cnt_q <= '0;
      end else if (swr_req) begin
         ctrl_q    <= '0;
         per_q     <= '0;
         rst_cnt_q <= RC_W'(RST_LEN);
      end else if (busy) begin
         rst_cnt_q <= rst_cnt_q - 1'b1;
      end else begin
         if (sel_ctrl) ctrl_q <= wr_data & CTRL_MASK;
         if (sel_per)  per_q  <= wr_data[CNT_W-1:0];
      end
   end

   pwm_sample_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH), .CW(LVL_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (clr),
      .push  (sel_duty),
      .din   (wr_data[CNT_W-1:0]),
      .pop   (pop),
      .dout  (fifo_head),
      .level (level)
   );
   assign fifo_empty = (level == '0);

   pwm_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .en         (ctrl_q[BIT_EN]),
      .prescale   (ctrl_q[PS_LSB +: PS_W]),
      .period     (per_q),
      .fifo_empty (fifo_empty),
      .fifo_head  (fifo_head),
      .pop        (pop),
      .running    (running),
      .count      (count),
      .duty       (duty)
   );

   pwm_out_stage #(.CNT_W(CNT_W)) u_out (
      .en      (ctrl_q[BIT_EN]),
      .running (running),
      .count   (count),
      .duty    (duty),
      .invert  (ctrl_q[BIT_POL]),
      .pwm_o   (pwm_out)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(OFF_CTRL))      rd_data = ctrl_q | (32'(busy) << BIT_SWR);
      else if (rd_addr == ADDR_W'(OFF_STAT)) rd_data = 32'(level);
      else if (rd_addr == ADDR_W'(OFF_DUTY)) rd_data = 32'(duty);
      else if (rd_addr == ADDR_W'(OFF_PER))  rd_data = 32'(per_q);
   end

   AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[BIT_EN] |-> (pwm_out == ctrl_q[BIT_POL])); // R10
   AST_SWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (per_q == '0) && (level == '0) && (ctrl_q == '0)); // R11
   AST_SWR_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_cnt_q == RC_W'(1)) |=> !busy); // R11
endmodule

// File: tb/pwm_fifo_ctrl_tb.sv
module pwm_fifo_ctrl_tb;
   localparam int RST_LEN = 4;
   localparam logic [31:0] MASK = 32'h03C7_FFF1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   wire  [31:0] rd_data;
   wire         pwm_out;

   always #10 clk = ~clk;

   pwm_fifo_ctrl #(.RST_LEN(RST_LEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
   );

   // behavioural reference state
   logic [31:0] m_ctrl = '0;
   logic [15:0] m_per = '0, m_act = '0;
   int          m_pcnt = 0, m_cnt = 0, m_rst = 0;
   bit          m_run = 0;
   logic [15:0] m_q[$];

   int    vecs = 0, errs = 0, rd_sel = 0;
   string tag = "R2";
   bit    done = 0;

   function automatic logic [31:0] exp_rd(input logic [4:0] a);
      case (a)
         5'h00:   return m_ctrl | ((m_rst != 0) ? 32'h8 : 32'h0);
         5'h04:   return 32'(m_q.size());
         5'h0C:   return 32'(m_act);
         5'h10:   return 32'(m_per);
         default: return 32'h0;
      endcase
   endfunction

   task automatic check();
      logic        eo;
      logic [31:0] er;
      eo = ((m_ctrl[0] && m_run && (m_cnt < int'(m_act))) ? 1'b1 : 1'b0) ^ m_ctrl[18];
      er = exp_rd(rd_addr);
      vecs += 2;
      if (pwm_out !== eo) begin
         errs++;
         $display("FAIL %s pwm_out actual=%b expected=%b t=%0t", tag, pwm_out, eo, $time);
      end
      if (rd_data !== er) begin
         errs++;
         $display("FAIL %s rd_data[%h] actual=%h expected=%h t=%0t", tag, rd_addr, rd_data, er, $time);
      end
   endtask

   task automatic model(input bit we, input logic [4:0] a, input logic [31:0] d);
      bit busy, swr, clr, en, start;
      int ps, last, sz;
      busy  = (m_rst != 0);
      swr   = we && !busy && (a == 5'h00) && d[3];
      clr   = swr || busy;
      en    = m_ctrl[0];
      ps    = int'(m_ctrl[15:4]);
      last  = int'(m_per) + 1;
      sz    = m_q.size();
      start = 0;
      if (clr) begin
         m_pcnt = 0; m_cnt = 0; m_run = 0; m_act = '0;
      end else if (!en) begin
         m_pcnt = 0; m_cnt = 0; m_run = 0;
      end else if (!m_run) begin
         m_run = 1; start = 1;
      end else if (m_pcnt >= ps) begin
         m_pcnt = 0;
         if (m_cnt >= last) begin m_cnt = 0; start = 1; end
         else m_cnt++;
      end else begin
         m_pcnt++;
      end
      if (clr) m_q.delete();
      else begin
         if (start && sz > 0) m_act = m_q.pop_front();
         if (we && !busy && a == 5'h0C && sz < 4) m_q.push_back(d[15:0]);
      end
      if (swr) begin
         m_ctrl = '0; m_per = '0; m_rst = RST_LEN;
      end else if (busy) begin
         m_rst--;
      end else if (we) begin
         if (a == 5'h00) m_ctrl = d & MASK;
         if (a == 5'h10) m_per = d[15:0];
      end
   endtask

   task automatic step(input bit we, input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      check();
      wr_en = we; wr_addr = a; wr_data = d;
      model(we, a, d);
      rd_sel++;
      case (rd_sel % 5)
         0: rd_addr = 5'h00;
         1: rd_addr = 5'h04;
         2: rd_addr = 5'h0C;
         3: rd_addr = 5'h10;
         default: rd_addr = 5'h08;
      endcase
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 5'h00, 32'h0);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      step(1, a, d);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model(0, 5'h00, 32'h0);
      tag = "R2";  idle(6);                       // reset state
      tag = "R1";                                 // map, mask, unmapped offset
      wr(5'h00, 32'hFFFF_FFF6); idle(5);
      wr(5'h10, 32'h0001_2345); idle(5);
      wr(5'h08, 32'hDEAD_BEEF); idle(5);
      tag = "R10"; wr(5'h00, 32'h0); idle(5);     // clearing stops, output inactive
      tag = "R3";                                 // four entries queued
      wr(5'h0C, 32'h1); wr(5'h0C, 32'h2); wr(5'h0C, 32'h3); wr(5'h0C, 32'h4); idle(5);
      tag = "R4";  wr(5'h0C, 32'h5); idle(5);     // fifth entry dropped
      tag = "R6/R7/R8";                           // period 5, pops each rollover, then hold
      wr(5'h10, 32'h3); wr(5'h00, 32'h1); idle(40);
      tag = "R5";                                 // divide by 3
      wr(5'h00, 32'h21); wr(5'h0C, 32'h0); wr(5'h0C, 32'h7); wr(5'h0C, 32'h3); idle(70);
      tag = "R9";  wr(5'h00, 32'h0004_0021); idle(40);
      tag = "R9";  wr(5'h00, 32'h0004_0000); idle(5);  // inverted while idle
      tag = "R11";                                // reset mid-run, writes ignored while busy
      wr(5'h00, 32'h1); wr(5'h0C, 32'h2); idle(8);
      wr(5'h0C, 32'h3); wr(5'h0C, 32'h4);
      wr(5'h00, 32'h0004_0008);
      wr(5'h10, 32'h9); wr(5'h0C, 32'h2); wr(5'h00, 32'h1); idle(6);
      wr(5'h10, 32'h2); wr(5'h00, 32'h1); idle(6);
      wr(5'h0C, 32'h2); idle(15);
      tag = "R10"; wr(5'h00, 32'h0); idle(10);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog tag=%s actual=hung expected=finished", tag);
         summary();
         $finish;
      end
   end
endmodule